// File: doc/BRIEF.md
# Grid Inverter Supervisor

This block is the mode controller for a grid-connected inverter. It has four externally visible modes, coded on `mode` as power-on (0), standby (1), on (2) and fault (3). A single push key, sampled through a synchronizer and a debounce filter, is timed against a one-millisecond tick. Holding it down long enough starts the inverter, stops it, or acknowledges a fault, depending on the current mode. The switching enables for the PWM stage and for the thyristor bridge are produced here. They rise only at a grid zero crossing, so the first output current starts from zero.

The supervisor also watches the grid and the plant. It returns to standby if the general conditions drop, if the grid leaves its window for five zero-crossing strobes (or for 100 ms with no strobes), or if islanding persists for 3.5 s. After any of these automatic stops it restarts by itself once everything has been healthy for 0.8 s. Overcurrent, overvoltage, over-temperature and current-limit faults force fault mode at once. A status LED shows the mode as a blink rate. All time constants are parameters counted in ticks.

Top module: `inverter_supervisor`

## Requirements
- R1: After reset `mode` is 0 and `pwm_en`, `scr_en` and `led` are 0. After INIT_MS ticks the mode becomes 1 (standby) without any input.
- R2: A recognised long press in standby, with `cond_ok`=1, `grid_ok`=1 and `island`=0, sets `mode` to 2. `pwm_en` and `scr_en` stay 0 until a `zc_strobe` pulse is sampled, and both are 1 from the next cycle on.
- R3: A long press in standby while any of `cond_ok`, `grid_ok` or `!island` is false leaves `mode` at 1.
- R4: A long press in mode 2 sets `mode` to 1 and clears both enables.
- R5: A press is long once the debounced key has been high for LONG_MS (1000) ticks. It acts once per press, however long the key is held. Presses shorter than that, and glitches shorter than DEB_MS (20) ticks, have no effect.
- R6: While `flt_oc`, `flt_ov`, `flt_ot` or `flt_ilim` is 1 and mode is not 0, the next cycle has `mode` 3 and both enables 0. In mode 0 the fault inputs are ignored.
- R7: A long press in mode 3 moves to mode 1 only when no fault input is active. Otherwise the mode stays 3.
- R8: The LED lights for LED_ON_MS ticks at the start of each period. The period is 1200 ticks in standby and 2400 ticks in mode 2. The LED is steadily lit in mode 3 and dark in mode 0.
- R9: In mode 2 with `grid_ok`=0, the fifth `zc_strobe`, or the 100th tick if strobes are missing, returns the block to mode 1.
- R10: In mode 2, `island` held high for ISL_MS (3500) consecutive ticks returns the block to mode 1. A shorter island episode has no effect.
- R11: After an automatic stop (R9, R10, R12), the block re-enters mode 2, gated by zero crossing, once all conditions have held for RESTART_MS (800) ticks. After a stop by key it stays in standby.
- R12: `cond_ok` falling in mode 2 gives mode 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-cycle pulse per millisecond |
| key_in | input | 1 | User key, high when pressed, asynchronous |
| zc_strobe | input | 1 | One-cycle grid zero-crossing pulse |
| cond_ok | input | 1 | General operating conditions satisfied |
| grid_ok | input | 1 | Grid voltage and frequency within range |
| island | input | 1 | Islanding detected |
| flt_oc | input | 1 | Output overcurrent fault |
| flt_ov | input | 1 | Secondary overvoltage fault |
| flt_ot | input | 1 | Over-temperature fault |
| flt_ilim | input | 1 | Repeated current-limit fault |
| mode | output | 2 | 0 power-on, 1 standby, 2 on, 3 fault |
| pwm_en | output | 1 | PWM stage enable |
| scr_en | output | 1 | Thyristor bridge enable |
| led | output | 1 | Status LED |

## Verification
The hardest state to reach is the automatic restart. The block must first be running with enables high, then stopped by the grid, island or condition monitors rather than by the key, then held healthy for the full restart window. A key stop must not count. The stimulus reaches this by starting with a long press and a zero-crossing pulse, then tripping each monitor in turn: counted strobes with the grid flag low, a held island flag, and a dropped condition flag. It samples the mode just before and just after the 800-tick window. Fixed-seed random glitches and short presses are mixed in to show that no sub-threshold key activity changes the mode.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [2:0] {
        ST_PWRON,
        ST_STBY,
        ST_ARM,
        ST_RUN,
        ST_FAULT
    } sup_state_e;

    typedef enum logic [1:0] {
        MODE_PWRON = 2'd0,
        MODE_STBY  = 2'd1,
        MODE_ON    = 2'd2,
        MODE_FAULT = 2'd3
    } sup_mode_e;

    typedef struct packed {
        logic oc;
        logic ov;
        logic ot;
        logic ilim;
    } hard_fault_t;

    function automatic sup_mode_e mode_of(sup_state_e s);
        case (s)
            ST_PWRON: return MODE_PWRON;
            ST_STBY:  return MODE_STBY;
            ST_ARM:   return MODE_ON;
            ST_RUN:   return MODE_ON;
            default:  return MODE_FAULT;
        endcase
    endfunction

    function automatic logic fault_active(hard_fault_t f);
        return f.oc | f.ov | f.ot | f.ilim;
    endfunction

endpackage

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic run,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick && cnt != W'(LIMIT - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && tick && (cnt == W'(LIMIT - 1));

endmodule

// File: rtl/sup_key_sense.sv
module sup_key_sense #(
    parameter int DEB_MS  = 20,
    parameter int LONG_MS = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic key_in,
    output logic long_press
);
    localparam int DW = $clog2(DEB_MS + 1);
    localparam int LW = $clog2(LONG_MS + 1);

    logic [1:0]    sync_q;
    logic          key_db;
    logic [DW-1:0] deb_cnt;
    logic [LW-1:0] hold_cnt;
    logic          fired;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[0], key_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            key_db  <= 1'b0;
            deb_cnt <= '0;
        end else if (sync_q[1] == key_db) begin
            deb_cnt <= '0;
        end else if (tick) begin
            if (deb_cnt == DW'(DEB_MS - 1)) begin
                key_db  <= sync_q[1];
                deb_cnt <= '0;
            end else begin
                deb_cnt <= deb_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt   <= '0;
            fired      <= 1'b0;
            long_press <= 1'b0;
        end else begin
            long_press <= 1'b0;
            if (!key_db) begin
                hold_cnt <= '0;
                fired    <= 1'b0;
            end else if (tick && !fired) begin
                if (hold_cnt == LW'(LONG_MS - 1)) begin
                    fired      <= 1'b1;
                    long_press <= 1'b1;
                end else begin
                    hold_cnt <= hold_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sup_grid_guard.sv
module sup_grid_guard #(
    parameter int ZC_LIMIT = 5,
    parameter int MS_LIMIT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic zc,
    input  logic watch,
    input  logic grid_ok,
    output logic trip
);
    localparam int ZW = $clog2(ZC_LIMIT + 1);

    logic          bad;
    logic [ZW-1:0] zc_cnt;
    logic          ms_done;

    assign bad = watch && !grid_ok;

    always_ff @(posedge clk) begin
        if (rst || !bad) begin
            zc_cnt <= '0;
        end else if (zc && zc_cnt != ZW'(ZC_LIMIT - 1)) begin
            zc_cnt <= zc_cnt + 1'b1;
        end
    end

    sup_hold_timer #(.LIMIT(MS_LIMIT)) u_ms (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .run  (bad),
        .done (ms_done)
    );

    assign trip = ms_done || (bad && zc && zc_cnt == ZW'(ZC_LIMIT - 1));

endmodule

// File: rtl/sup_led.sv
module sup_led
    import sup_pkg::*;
#(
    parameter int ON_MS    = 100,
    parameter int STBY_PER = 1200,
    parameter int RUN_PER  = 2400
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  sup_mode_e mode,
    input  logic      restart,
    output logic      led
);
    localparam int MAXP = (STBY_PER > RUN_PER) ? STBY_PER : RUN_PER;
    localparam int CW   = $clog2(MAXP + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = (mode == MODE_STBY) ? CW'(STBY_PER - 1) : CW'(RUN_PER - 1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt >= last) ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        case (mode)
            MODE_FAULT: led = 1'b1;
            MODE_STBY,
            MODE_ON:    led = (cnt < CW'(ON_MS));
            default:    led = 1'b0;
        endcase
    end

endmodule

// File: rtl/inverter_supervisor.sv
module inverter_supervisor
    import sup_pkg::*;
#(
    parameter int INIT_MS       = 50,
    parameter int DEB_MS        = 20,
    parameter int LONG_MS       = 1000,
    parameter int LED_ON_MS     = 100,
    parameter int STBY_BLINK_MS = 1200,
    parameter int ON_BLINK_MS   = 2400,
    parameter int GRID_ZC_LIMIT = 5,
    parameter int GRID_MS_LIMIT = 100,
    parameter int ISL_MS        = 3500,
    parameter int RESTART_MS    = 800
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1ms,
    input  logic       key_in,
    input  logic       zc_strobe,
    input  logic       cond_ok,
    input  logic       grid_ok,
    input  logic       island,
    input  logic       flt_oc,
    input  logic       flt_ov,
    input  logic       flt_ot,
    input  logic       flt_ilim,
    output logic [1:0] mode,
    output logic       pwm_en,
    output logic       scr_en,
    output logic       led
);
    sup_state_e  state, state_n;
    logic        resume, resume_n;
    hard_fault_t flt;
    logic        any_fault;
    logic        all_ok;
    logic        long_press;
    logic        init_done;
    logic        grid_trip;
    logic        isl_trip;
    logic        restart_due;
    logic        on_side;
    logic        mode_chg;

    assign flt       = '{oc: flt_oc, ov: flt_ov, ot: flt_ot, ilim: flt_ilim};
    assign any_fault = fault_active(flt);
    assign all_ok    = cond_ok && grid_ok && !island;
    assign on_side   = (state == ST_ARM) || (state == ST_RUN);

    sup_key_sense #(.DEB_MS(DEB_MS), .LONG_MS(LONG_MS)) u_key (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_1ms),
        .key_in     (key_in),
        .long_press (long_press)
    );

    sup_hold_timer #(.LIMIT(INIT_MS)) u_init (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_1ms),
        .run  (state == ST_PWRON),
        .done (init_done)
    );

    sup_grid_guard #(.ZC_LIMIT(GRID_ZC_LIMIT), .MS_LIMIT(GRID_MS_LIMIT)) u_grid (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_1ms),
        .zc      (zc_strobe),
        .watch   (on_side),
        .grid_ok (grid_ok),
        .trip    (grid_trip)
    );

    sup_hold_timer #(.LIMIT(ISL_MS)) u_island (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_1ms),
        .run  (on_side && island),
        .done (isl_trip)
    );

    sup_hold_timer #(.LIMIT(RESTART_MS)) u_restart (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_1ms),
        .run  ((state == ST_STBY) && resume && all_ok && !any_fault),
        .done (restart_due)
    );

    always_comb begin
        state_n  = state;
        resume_n = resume;
        unique case (state)
            ST_PWRON: begin
                if (init_done) state_n = ST_STBY;
            end
            ST_STBY: begin
                if (any_fault) begin
                    state_n  = ST_FAULT;
                    resume_n = 1'b0;
                end else if (long_press && all_ok) begin
                    state_n  = ST_ARM;
                    resume_n = 1'b0;
                end else if (restart_due) begin
                    state_n  = ST_ARM;
                    resume_n = 1'b0;
                end
            end
            ST_ARM, ST_RUN: begin
                if (any_fault) begin
                    state_n  = ST_FAULT;
                    resume_n = 1'b0;
                end else if (long_press) begin
                    state_n  = ST_STBY;
                    resume_n = 1'b0;
                end else if (!cond_ok || grid_trip || isl_trip) begin
                    state_n  = ST_STBY;
                    resume_n = 1'b1;
                end else if (state == ST_ARM && zc_strobe) begin
                    state_n = ST_RUN;
                end
            end
            default: begin
                if (long_press && !any_fault) state_n = ST_STBY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_PWRON;
            resume <= 1'b0;
        end else begin
            state  <= state_n;
            resume <= resume_n;
        end
    end

    assign mode_chg = (mode_of(state_n) != mode_of(state));

    sup_led #(.ON_MS(LED_ON_MS), .STBY_PER(STBY_BLINK_MS), .RUN_PER(ON_BLINK_MS)) u_led (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_1ms),
        .mode    (mode_of(state)),
        .restart (mode_chg),
        .led     (led)
    );

    assign mode   = mode_of(state);
    assign pwm_en = (state == ST_RUN);
    assign scr_en = (state == ST_RUN);

endmodule

// File: rtl/sup_checker.sv
module sup_checker (
    input logic       clk,
    input logic       rst,
    input logic       zc_strobe,
    input logic       flt_oc,
    input logic       flt_ov,
    input logic       flt_ot,
    input logic       flt_ilim,
    input logic [1:0] mode,
    input logic       pwm_en,
    input logic       scr_en,
    input logic       led
);
    // R1: power-on only leaves toward standby
    a_r1_pwron_exit: assert property (@(posedge clk) disable iff (rst)
        mode == 2'd0 |=> (mode == 2'd0 || mode == 2'd1));

    // R2: enables only in on mode, first rise follows a zero crossing
    a_r2_enable_in_on: assert property (@(posedge clk) disable iff (rst)
        (pwm_en || scr_en) |-> mode == 2'd2);

    a_r2_rise_at_zc: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_en) |-> $past(zc_strobe));

    // R6: hard fault forces fault mode next cycle outside power-on
    a_r6_fault_entry: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd0 && (flt_oc || flt_ov || flt_ot || flt_ilim)) |=> mode == 2'd3);

    a_r6_fault_off: assert property (@(posedge clk) disable iff (rst)
        mode == 2'd3 |-> (!pwm_en && !scr_en));

    // R8: steady LED in fault, dark in power-on
    a_r8_fault_led: assert property (@(posedge clk) disable iff (rst)
        mode == 2'd3 |-> led);

    a_r8_pwron_dark: assert property (@(posedge clk) disable iff (rst)
        mode == 2'd0 |-> !led);

endmodule

bind inverter_supervisor sup_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .zc_strobe (zc_strobe),
    .flt_oc    (flt_oc),
    .flt_ov    (flt_ov),
    .flt_ot    (flt_ot),
    .flt_ilim  (flt_ilim),
    .mode      (mode),
    .pwm_en    (pwm_en),
    .scr_en    (scr_en),
    .led       (led)
);

// File: tb/tb_inverter_supervisor.sv
module tb_inverter_supervisor;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_1ms = 1'b0;
    logic key_in = 1'b0, zc_strobe = 1'b0;
    logic cond_ok = 1'b1, grid_ok = 1'b1, island = 1'b0;
    logic flt_oc = 1'b0, flt_ov = 1'b0, flt_ot = 1'b0, flt_ilim = 1'b0;
    logic [1:0] mode;
    logic pwm_en, scr_en, led;

    int checks = 0;
    int failures = 0;
    int tick_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    inverter_supervisor dut (
        .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .key_in(key_in),
        .zc_strobe(zc_strobe), .cond_ok(cond_ok), .grid_ok(grid_ok),
        .island(island), .flt_oc(flt_oc), .flt_ov(flt_ov), .flt_ot(flt_ot),
        .flt_ilim(flt_ilim), .mode(mode), .pwm_en(pwm_en), .scr_en(scr_en),
        .led(led)
    );

    initial begin
        bit phase = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            phase = ~phase;
            tick_1ms = phase;
            if (phase) tick_cnt++;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ticks(int n);
        int t0 = tick_cnt;
        while (tick_cnt < t0 + n) @(negedge clk);
    endtask

    task automatic press(int n);
        @(negedge clk) key_in = 1'b1;
        wait_ticks(n);
        @(negedge clk) key_in = 1'b0;
        wait_ticks(40);
    endtask

    task automatic zc_pulse();
        @(negedge clk) zc_strobe = 1'b1;
        @(negedge clk) zc_strobe = 1'b0;
    endtask

    task automatic led_rise(output int t);
        logic prev = led;
        int guard = 0;
        forever begin
            @(negedge clk);
            guard++;
            if (!prev && led) break;
            if (guard > 20000) break;
            prev = led;
        end
        t = tick_cnt;
    endtask

    function automatic int exp_after_long(int cur, bit ok, bit flt);
        case (cur)
            1: return flt ? 3 : (ok ? 2 : 1);
            2: return flt ? 3 : 1;
            3: return flt ? 3 : 1;
            default: return cur;
        endcase
    endfunction

    task automatic hit_fault(int k);
        @(negedge clk);
        case (k)
            0: flt_oc = 1'b1;
            1: flt_ov = 1'b1;
            2: flt_ot = 1'b1;
            default: flt_ilim = 1'b1;
        endcase
    endtask

    task automatic clear_faults();
        @(negedge clk);
        flt_oc = 1'b0; flt_ov = 1'b0; flt_ot = 1'b0; flt_ilim = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int t1, t2;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        chk("R1 reset mode", mode, 0);
        chk("R1 reset enables", pwm_en | scr_en, 0);
        chk("R1 reset led", led, 0);
        rst = 1'b0;
        flt_ot = 1'b1;
        wait_ticks(20);
        chk("R6 fault ignored in power-on", mode, 0);
        wait_ticks(50);
        chk("R6 fault after power-on", mode, 3);
        chk("R8 fault led lit", led, 1);
        press(1100);
        chk("R7 clear refused while fault active", mode, exp_after_long(3, 1, 1));
        clear_faults();
        press(1100);
        chk("R7 clear to standby", mode, exp_after_long(3, 1, 0));

        led_rise(t1);
        led_rise(t2);
        chk("R8 standby blink period", t2 - t1, 1200);

        for (int i = 0; i < 8; i++) begin
            int len = (i % 2 == 0) ? int'($urandom_range(1, 15)) : int'($urandom_range(100, 900));
            press(len);
            chk("R5 short press or glitch ignored", mode, 1);
        end

        cond_ok = 1'b0;
        press(1100);
        chk("R3 start refused on bad conditions", mode, exp_after_long(1, 0, 0));
        cond_ok = 1'b1;
        island = 1'b1;
        press(1100);
        chk("R3 start refused while islanded", mode, 1);
        island = 1'b0;

        press(1100);
        chk("R2 on after long press", mode, exp_after_long(1, 1, 0));
        chk("R2 enables wait for zero crossing", pwm_en, 0);
        zc_pulse();
        chk("R2 pwm after zero crossing", pwm_en, 1);
        chk("R2 scr after zero crossing", scr_en, 1);

        led_rise(t1);
        led_rise(t2);
        chk("R8 on blink period", t2 - t1, 2400);

        press(2500);
        chk("R5 held key acts once", mode, 1);
        chk("R4 enables off after key stop", pwm_en, 0);
        wait_ticks(1000);
        chk("R11 no restart after key stop", mode, 1);

        press(1100);
        zc_pulse();
        @(negedge clk) grid_ok = 1'b0;
        for (int i = 0; i < 4; i++) begin
            wait_ticks(5);
            zc_pulse();
        end
        chk("R9 four bad strobes tolerated", pwm_en, 1);
        wait_ticks(5);
        zc_pulse();
        chk("R9 fifth bad strobe stops", mode, 1);
        grid_ok = 1'b1;
        wait_ticks(700);
        chk("R11 restart not early", mode, 1);
        wait_ticks(200);
        chk("R11 restart after grid recovery", mode, 2);
        chk("R11 restart waits zero crossing", pwm_en, 0);
        zc_pulse();
        chk("R11 running after restart", pwm_en, 1);

        @(negedge clk) grid_ok = 1'b0;
        wait_ticks(110);
        chk("R9 timeout without strobes", mode, 1);
        grid_ok = 1'b1;
        wait_ticks(900);
        zc_pulse();

        island = 1'b1;
        wait_ticks(1000);
        island = 1'b0;
        wait_ticks(10);
        chk("R10 short island tolerated", pwm_en, 1);
        island = 1'b1;
        wait_ticks(3400);
        chk("R10 island before limit", mode, 2);
        wait_ticks(200);
        chk("R10 island stop", mode, 1);
        island = 1'b0;
        wait_ticks(900);
        chk("R11 restart after island", mode, 2);
        zc_pulse();

        @(negedge clk) cond_ok = 1'b0;
        @(negedge clk);
        chk("R12 condition loss stops", mode, 1);
        chk("R12 enables off", pwm_en | scr_en, 0);
        cond_ok = 1'b1;
        wait_ticks(900);
        chk("R11 restart after condition return", mode, 2);
        zc_pulse();

        hit_fault(int'($urandom_range(0, 3)));
        @(negedge clk);
        chk("R6 fault from on", mode, 3);
        chk("R6 enables off in fault", pwm_en, 0);
        clear_faults();
        press(1100);
        chk("R7 clear from fault", mode, 1);
        for (int k = 0; k < 4; k++) begin
            hit_fault(k);
            @(negedge clk);
            chk("R6 fault from standby", mode, 3);
            clear_faults();
            press(1100);
            chk("R7 clear each fault", mode, 1);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule